// File: doc/BRIEF.md
# Serial-Loaded Eight-Channel Output Latch

This block receives one command byte per device over a four-wire serial link and holds eight channel enables in an output latch. The host pulls the active-low select line low, clocks data in on rising serial-clock edges with the most significant bit first, then releases select. The received byte moves into the latch only if the number of serial-clock pulses in that select period is a non-zero whole multiple of eight. A spike on the clock line or a short or long burst therefore leaves the channels as they were.

The serial output carries the shift-register contents onward. Several instances can share clock and select, with each serial output wired to the next serial input. A sixteen-pulse frame then places the first byte sent in the second device and the second byte in the first. An active-low disable input clears the latch and turns all channels off. A diagnostic flag reports whether any per-channel fault input is active.

All pins are brought into one system clock through two-flop synchronisers, and edges are found in that domain. The system clock must run at least four times faster than the serial clock.

Top module: `spi_out_latch`

## Requirements
- R1: After synchronous reset, all channel outputs are 0, the serial-output enable is 0, and the shift register holds all zeros. The first bits shifted out after reset are therefore 0.
- R2: While select is low, serial input is sampled on each rising serial-clock edge, MSB first. After an 8-pulse frame, channel output bit 7 equals the first bit sent and bit 0 equals the last.
- R3: When select rises, the latch takes the shift register only if the pulse count in that frame is a multiple of 8. A frame of 7 or 9 pulses leaves the channel outputs unchanged.
- R4: A frame with zero serial-clock pulses does not change the channel outputs.
- R5: While select is high, serial-clock and serial-input activity has no effect. The shift register is kept, and the next frame shifts out the previous contents unchanged.
- R6: While select is high, the serial-output enable and the serial-output data are both 0. Once select falls, the output drives the shift-register MSB. After each falling serial-clock edge it presents the next bit.
- R7: With two instances chained output-to-input and sharing clock and select, a 16-pulse frame leaves the first byte sent in the second instance and the second byte in the first.
- R8: While disable is low, all channel outputs are 0 and the latch is cleared. A frame completed during disable does not load. After disable is released, the outputs stay 0 until a valid frame loads new data.
- R9: The diagnostic flag is the OR of the eight fault inputs and follows them within 2 system clocks.
- R10: A channel output bit of 1 means that channel is on and 0 means off. In a single device, a 16-pulse frame latches the last 8 bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock, idle high |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, 0 when not enabled |
| sdo_oe_o | output | 1 | Serial-output driver enable; the pad is high impedance when 0 |
| dis_n_i | input | 1 | Active-low disable of all channels |
| fault_i | input | 8 | Per-channel over-temperature faults |
| chan_on_o | output | 8 | Latched channel enables |
| diag_o | output | 1 | OR of all fault inputs |

## Verification
Each result has a fixed latency counted from a pin change. The channel outputs settle 4 system cycles after select rises: two synchroniser stages, an edge register and the commit register. A serial-output bit settles 3 cycles after a falling serial-clock edge. Disable clears the outputs after 3 cycles, and the diagnostic flag follows the faults after 2. The bench holds each serial-clock phase for 6 system cycles, samples the serial output at the end of the low phase, and waits 8 cycles after select rises before it compares the channels. Every sample therefore falls after the latest settling point and before the next stimulus.

// File: rtl/spo_pkg.sv
package spo_pkg;

    parameter int unsigned SPO_NCH    = 8;
    parameter int unsigned SPO_STAGES = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } spo_edge_t;

    function automatic spo_edge_t spo_edge(input logic prev, input logic cur);
        spo_edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

endpackage

// File: rtl/spo_sync.sv
module spo_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= RST_VAL;
            else     stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spo_frame.sv
module spo_frame
    import spo_pkg::*;
#(
    parameter int unsigned NCH = SPO_NCH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n_s,
    input  logic           sclk_s,
    input  logic           sdi_s,
    output logic [NCH-1:0] shreg,
    output logic           commit,
    output logic           sdo_q,
    output logic           oe_q
);
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    logic          cs_d, sclk_d;
    logic [CW-1:0] cnt;
    logic          seen;
    spo_edge_t     cs_e, sclk_e;
    logic          active;

    always_comb begin
        cs_e   = spo_edge(cs_d, cs_n_s);
        sclk_e = spo_edge(sclk_d, sclk_s);
        active = ~cs_n_s & ~cs_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b1;
            shreg  <= '0;
            cnt    <= '0;
            seen   <= 1'b0;
            sdo_q  <= 1'b0;
            oe_q   <= 1'b0;
            commit <= 1'b0;
        end else begin
            cs_d   <= cs_n_s;
            sclk_d <= sclk_s;
            oe_q   <= ~cs_n_s;
            commit <= 1'b0;
            if (cs_e.fall) begin
                cnt   <= '0;
                seen  <= 1'b0;
                sdo_q <= shreg[NCH-1];
            end else if (active) begin
                if (sclk_e.rise) begin
                    shreg <= {shreg[NCH-2:0], sdi_s};
                    cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
                    seen  <= 1'b1;
                end
                if (sclk_e.fall) begin
                    sdo_q <= shreg[NCH-1];
                end
            end
            if (cs_e.rise) begin
                commit <= seen && (cnt == '0);
            end
        end
    end
endmodule

// File: rtl/spo_latch.sv
module spo_latch
    import spo_pkg::*;
#(
    parameter int unsigned NCH = SPO_NCH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           commit,
    input  logic [NCH-1:0] shreg,
    input  logic           dis_n_s,
    input  logic [NCH-1:0] fault_s,
    output logic [NCH-1:0] chan_on,
    output logic           diag
);
    always_ff @(posedge clk) begin
        if (rst || !dis_n_s) chan_on <= '0;
        else if (commit)     chan_on <= shreg;
    end

    assign diag = |fault_s;
endmodule

// File: rtl/spi_out_latch.sv
module spi_out_latch
    import spo_pkg::*;
#(
    parameter int unsigned NCH    = SPO_NCH,
    parameter int unsigned STAGES = SPO_STAGES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n_i,
    input  logic           sclk_i,
    input  logic           sdi_i,
    output logic           sdo_o,
    output logic           sdo_oe_o,
    input  logic           dis_n_i,
    input  logic [NCH-1:0] fault_i,
    output logic [NCH-1:0] chan_on_o,
    output logic           diag_o
);
    logic [3:0]     pin_s;
    logic           cs_n_s, sclk_s, sdi_s, dis_n_s;
    logic [NCH-1:0] fault_s;
    logic [NCH-1:0] shreg;
    logic           commit, sdo_q, oe_q;

    spo_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1011)) u_pin_sync (
        .clk(clk), .rst(rst),
        .d({dis_n_i, sdi_i, sclk_i, cs_n_i}),
        .q(pin_s)
    );

    assign cs_n_s  = pin_s[0];
    assign sclk_s  = pin_s[1];
    assign sdi_s   = pin_s[2];
    assign dis_n_s = pin_s[3];

    spo_sync #(.W(NCH), .STAGES(STAGES), .RST_VAL('0)) u_fault_sync (
        .clk(clk), .rst(rst), .d(fault_i), .q(fault_s)
    );

    spo_frame #(.NCH(NCH)) u_frame (
        .clk(clk), .rst(rst),
        .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .shreg(shreg), .commit(commit), .sdo_q(sdo_q), .oe_q(oe_q)
    );

    spo_latch #(.NCH(NCH)) u_latch (
        .clk(clk), .rst(rst),
        .commit(commit), .shreg(shreg),
        .dis_n_s(dis_n_s), .fault_s(fault_s),
        .chan_on(chan_on_o), .diag(diag_o)
    );

    assign sdo_oe_o = oe_q;
    assign sdo_o    = oe_q & sdo_q;
endmodule

// File: rtl/spo_checker.sv
module spo_checker #(
    parameter int unsigned NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cs_n_s,
    input logic           dis_n_s,
    input logic           commit,
    input logic [NCH-1:0] fault_i,
    input logic [NCH-1:0] chan_on_o,
    input logic           sdo_oe_o,
    input logic           diag_o
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R6: driver stays off one cycle after the synchronised select is high
    a_r6_sdo_hiz: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n_s) |-> !sdo_oe_o);

    // R3: channel outputs move only on a commit or a disable
    a_r3_latch_holds: assert property (@(posedge clk) disable iff (rst)
        !$stable(chan_on_o) |-> ($past(commit) || !$past(dis_n_s)));

    // R8: disable empties the latch on the next cycle
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !dis_n_s |=> (chan_on_o == '0));

    // R9: flag equals OR of faults once they have been steady long enough
    a_r9_diag_or: assert property (@(posedge clk) disable iff (rst)
        ((age == 2'd3) && $stable(fault_i) && ($past(fault_i) == $past(fault_i, 2)))
        |-> (diag_o == |fault_i));
endmodule

bind spi_out_latch spo_checker #(.NCH(NCH)) chk_i (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .dis_n_s(dis_n_s),
    .commit(commit), .fault_i(fault_i), .chan_on_o(chan_on_o),
    .sdo_oe_o(sdo_oe_o), .diag_o(diag_o)
);

// File: tb/spi_out_latch_tb_top.sv
module spi_out_latch_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0, dis_n = 1'b1;
    logic [7:0] fault = '0;
    logic       sdo1, oe1, sdo2, oe2, diag1, diag2;
    logic [7:0] on1, on2;

    spi_out_latch dut_i (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo1), .sdo_oe_o(oe1), .dis_n_i(dis_n), .fault_i(fault),
        .chan_on_o(on1), .diag_o(diag1)
    );

    spi_out_latch chain_i (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdo1),
        .sdo_o(sdo2), .sdo_oe_o(oe2), .dis_n_i(dis_n), .fault_i('0),
        .chan_on_o(on2), .diag_o(diag2)
    );

    int n_chk = 0, n_err = 0;
    logic [7:0] m1 = '0, m2 = '0, l1 = '0, l2 = '0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic len_ok(input int n);
        return (n > 0) && (n % 8 == 0);
    endfunction

    task automatic frame(input int nbits, input logic [31:0] data, input string req);
        logic b2;
        cs_n = 1'b0;
        wclk(6);
        chk("R6 driver on after select falls", {7'b0, oe1}, 8'h01);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdi  = data[nbits-1-i];
            wclk(6);
            chk("R6 serial out bit", {7'b0, sdo1}, {7'b0, m1[7]});
            chk("R7 chained serial out bit", {7'b0, sdo2}, {7'b0, m2[7]});
            b2 = m1[7];
            m2 = {m2[6:0], b2};
            m1 = {m1[6:0], sdi};
            sclk = 1'b1;
            wclk(6);
        end
        cs_n = 1'b1;
        wclk(8);
        if (!dis_n) begin
            l1 = '0; l2 = '0;
        end else if (len_ok(nbits)) begin
            l1 = m1; l2 = m2;
        end
        chk(req, on1, l1);
        chk("R7 second device latch", on2, l2);
        chk("R6 released output idle", {6'b0, oe1, sdo1}, 8'h00);
    endtask

    initial begin
        #(100000 * 8);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        wclk(4);
        rst = 1'b0;
        wclk(3);
        // R1 reset state
        chk("R1 channels off after reset", on1, 8'h00);
        chk("R1 driver off after reset", {7'b0, oe1}, 8'h00);
        chk("R9 flag clear with no faults", {7'b0, diag1}, 8'h00);

        // R2 / R1: first frame shifts out zeros, latches A5
        frame(8, 32'hA5, "R2 8-pulse frame loads byte");
        // R10: single device keeps last 8 bits of 16; R7 chain gets first byte
        frame(16, 32'h3CC3, "R10 16-pulse frame loads last byte");
        chk("R7 second device holds first byte", on2, 8'h3C);
        chk("R10 first device holds last byte", on1, 8'hC3);
        // R3 wrong counts
        frame(7, 32'h55, "R3 7-pulse frame ignored");
        frame(9, 32'h1FF, "R3 9-pulse frame ignored");
        // R4 empty frame
        frame(0, 32'h0, "R4 empty frame ignored");

        // R5 activity with select high
        for (int i = 0; i < 10; i++) begin
            sclk = 1'b0; sdi = i[0]; wclk(6);
            sclk = 1'b1; wclk(6);
        end
        chk("R5 outputs unchanged by idle clocking", on1, l1);
        chk("R6 driver off while select high", {6'b0, oe1, sdo1}, 8'h00);
        frame(8, 32'h96, "R5 shift contents kept across idle clocking");

        // R8 disable
        dis_n = 1'b0;
        wclk(6);
        chk("R8 disable clears outputs", on1, 8'h00);
        l1 = '0; l2 = '0;
        frame(8, 32'hFF, "R8 frame during disable ignored");
        dis_n = 1'b1;
        wclk(6);
        chk("R8 outputs stay off after release", on1, 8'h00);
        frame(8, 32'h81, "R8 valid frame after release loads");

        // R9 fault OR
        for (int i = 0; i < 12; i++) begin
            fault = (i < 2) ? (8'h01 << i) : 8'($urandom_range(0, 255));
            if (i == 5) fault = 8'h00;
            wclk(3);
            chk("R9 flag is OR of faults", {7'b0, diag1}, {7'b0, |fault});
        end
        fault = '0;

        // random frames
        for (int i = 0; i < 30; i++) begin
            int n;
            n = (i % 4 == 0) ? 8 * (1 + (i % 3)) : int'($urandom_range(0, 24));
            frame(n, $urandom, len_ok(n) ? "R2 random full frame loads" : "R3 random odd frame ignored");
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule